// File: doc/BRIEF.md
# Temporal Gray-Level Dithering Unit

The unit turns a 4-bit gray level per pixel into a single on/off bit for a monochrome passive panel. Intermediate shades come from frame rate control: over a short run of frames a pixel is lit in a fraction of them, and neighbouring pixels within a group of four are lit in different frames so the panel does not flicker as a whole. The fractions come from eight programmable pattern registers. Each register holds one 4-bit spatial pattern per frame of its cycle. Dark and light levels whose fractions add up to one share a register, and the dark level takes the pattern inverted.

Software writes the pattern registers through an address/data port. A write lands in a staging copy and is used only from the next start-of-frame pulse onward. A frame-phase counter for each cycle length (2, 3, 4, 5 and 7 frames) chooses the pattern of the current frame. The pixel's horizontal position chooses the bit within that pattern.

Top module: `frc_dither`

## Requirements
- R1: Gray level 0 always gives 0 and gray level 15 always gives 1, whatever the register contents and the frame.
- R2: Levels 14, 13, 12, 11, 10, 9 and 8 use, uninverted, the register at address 7, 4, 2, 6, 1, 3 and 5 respectively. Address map: 0 = 1/2, 1 = 2/3, 2 = 3/4, 3 = 3/5, 4 = 4/5, 5 = 4/7, 6 = 5/7, 7 = 6/7.
- R3: Levels 7, 6, 5, 4, 3, 2 and 1 use the register at address 0, 5, 3, 1, 2, 4 and 7 respectively, with the selected bit inverted.
- R4: For a pixel whose horizontal coordinate has m = x mod 4, the output is bit (3 − m) of the current 4-bit pattern. Coordinate bits above bit 1 have no effect. Example: with 0xA5A5F at address 3, level 9 at m = 0 gives 1, 0, 1, 0 over the first four frames.
- R5: The register at an address with cycle length d uses the low 4·d bits of the write data. Bits above those are dropped. In frame phase k the pattern is nibble k counted from the most significant nibble of that 4·d-bit field. The cycle lengths are d = 2 for address 0, 3 for address 1, 4 for address 2, 5 for addresses 3 and 4, and 7 for addresses 5 to 7.
- R6: The frame phase of cycle length d is f mod d. Here f counts start-of-frame pulses after the first pulse following reset. The first pulse leaves every phase at 0.
- R7: A write (wr_en_i high, with address and data) changes the pixel output only from the next start-of-frame pulse. Pixels that come earlier still use the old pattern.
- R8: pix_o changes one clock after a cycle with pix_valid_i high. It holds its value while pix_valid_i is low, and it is 0 after reset.
- R9: After reset all pattern registers and frame phases are 0, so levels 1 to 7 give 1 and levels 8 to 14 give 0 until the first write has been committed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pix_valid_i | input | 1 | Pixel strobe |
| gray_i | input | 4 | Gray level of the pixel |
| pix_x_i | input | X_W | Horizontal coordinate of the pixel |
| sof_i | input | 1 | Start-of-frame pulse |
| wr_en_i | input | 1 | Pattern register write enable |
| wr_addr_i | input | 3 | Pattern register address |
| wr_data_i | input | 28 | Pattern write data, right-aligned |
| pix_o | output | 1 | Registered pixel on/off bit |

## Verification
The checker verifies four things on every cycle: the output holds while no pixel is presented, levels 0 and 15 are forced, and the active patterns and frame phases change only on a start-of-frame pulse. Which register, nibble and bit a given level picks, the inversion of the dark half, the wrap of each phase counter and the deferral of writes depend on accumulated frame history. Only the bench shows these. It sweeps every level and every position across more than one full common cycle of all counters and writes in the middle of a frame.

// File: rtl/frc_pkg.sv
package frc_pkg;
  localparam int unsigned GRAY_W  = 4;
  localparam int unsigned NIB_W   = 4;
  localparam int unsigned NUM_PAT = 8;
  localparam int unsigned PAT_AW  = $clog2(NUM_PAT);
  localparam int unsigned MAX_DEN = 7;
  localparam int unsigned PAT_W   = NIB_W * MAX_DEN;
  localparam int unsigned NUM_DEN = 5;
  localparam int unsigned PH_W    = $clog2(MAX_DEN);
  localparam int unsigned SH_W    = $clog2(PAT_W);

  // cycle length of each phase counter slot
  function automatic int unsigned slot_den(input int unsigned s);
    case (s)
      0: return 2;
      1: return 3;
      2: return 4;
      3: return 5;
      default: return 7;
    endcase
  endfunction

  // phase counter slot used by each pattern register
  function automatic int unsigned pat_slot(input int unsigned r);
    case (r)
      0: return 0;
      1: return 1;
      2: return 2;
      3, 4: return 3;
      default: return 4;
    endcase
  endfunction

  typedef struct packed {
    logic              fixed;
    logic              fixed_val;
    logic              inv;
    logic [PAT_AW-1:0] sel;
  } gmap_t;

  function automatic gmap_t gray_map(input logic [GRAY_W-1:0] g);
    gmap_t m;
    m = '0;
    case (g)
      4'd0:  begin m.fixed = 1'b1; m.fixed_val = 1'b0; end
      4'd15: begin m.fixed = 1'b1; m.fixed_val = 1'b1; end
      4'd14: m.sel = 3'd7;
      4'd13: m.sel = 3'd4;
      4'd12: m.sel = 3'd2;
      4'd11: m.sel = 3'd6;
      4'd10: m.sel = 3'd1;
      4'd9:  m.sel = 3'd3;
      4'd8:  m.sel = 3'd5;
      4'd7:  begin m.sel = 3'd0; m.inv = 1'b1; end
      4'd6:  begin m.sel = 3'd5; m.inv = 1'b1; end
      4'd5:  begin m.sel = 3'd3; m.inv = 1'b1; end
      4'd4:  begin m.sel = 3'd1; m.inv = 1'b1; end
      4'd3:  begin m.sel = 3'd2; m.inv = 1'b1; end
      4'd2:  begin m.sel = 3'd4; m.inv = 1'b1; end
      default: begin m.sel = 3'd7; m.inv = 1'b1; end
    endcase
    return m;
  endfunction
endpackage

// File: rtl/frc_pattern_bank.sv
module frc_pattern_bank
  import frc_pkg::*;
(
  input  logic                            clk_i,
  input  logic                            rst_ni,
  input  logic                            wr_en_i,
  input  logic [PAT_AW-1:0]               wr_addr_i,
  input  logic [PAT_W-1:0]                wr_data_i,
  input  logic                            commit_i,
  output logic [NUM_PAT-1:0][PAT_W-1:0]   active_o
);
  for (genvar g = 0; g < NUM_PAT; g++) begin : g_pat
    localparam int unsigned LEN = NIB_W * slot_den(pat_slot(g));
    localparam logic [PAT_W-1:0] MASK = (LEN >= PAT_W) ? {PAT_W{1'b1}}
                                      : ((PAT_W'(1) << LEN) - PAT_W'(1));
    logic [PAT_W-1:0] stage_q, act_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        stage_q <= '0;
        act_q   <= '0;
      end else begin
        if (wr_en_i && wr_addr_i == PAT_AW'(g)) stage_q <= wr_data_i & MASK;
        if (commit_i) act_q <= stage_q;
      end
    end
    assign active_o[g] = act_q;
  end
endmodule

// File: rtl/frc_frame_phase.sv
module frc_frame_phase
  import frc_pkg::*;
(
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          sof_i,
  output logic [NUM_DEN-1:0][PH_W-1:0]  phase_o
);
  logic started_q;
  logic adv;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    started_q <= 1'b0;
    else if (sof_i) started_q <= 1'b1;
  end
  // first frame after reset keeps phase 0
  assign adv = sof_i & started_q;

  for (genvar s = 0; s < NUM_DEN; s++) begin : g_cnt
    localparam logic [PH_W-1:0] LAST = PH_W'(slot_den(s) - 1);
    logic [PH_W-1:0] cnt_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)  cnt_q <= '0;
      else if (adv) cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + PH_W'(1);
    end
    assign phase_o[s] = cnt_q;
  end
endmodule

// File: rtl/frc_dither.sv
module frc_dither
  import frc_pkg::*;
#(
  parameter int unsigned X_W = 11
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 pix_valid_i,
  input  logic [GRAY_W-1:0]    gray_i,
  input  logic [X_W-1:0]       pix_x_i,
  input  logic                 sof_i,
  input  logic                 wr_en_i,
  input  logic [PAT_AW-1:0]    wr_addr_i,
  input  logic [PAT_W-1:0]     wr_data_i,
  output logic                 pix_o
);
  localparam int unsigned POS_W = $clog2(NIB_W);

  logic [NUM_PAT-1:0][PAT_W-1:0]  pat_act;
  logic [NUM_DEN-1:0][PH_W-1:0]   phase;

  gmap_t            map;
  logic [PAT_W-1:0] pat_sel;
  logic [2:0]       slot;
  int unsigned      den;
  logic [PH_W-1:0]  k;
  logic [SH_W-1:0]  sh;
  logic [NIB_W-1:0] nib;
  logic [POS_W-1:0] pos;
  logic             bit_on, pix_d, pix_q;
  logic             x_unused;

  frc_pattern_bank u_bank (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_en_i  (wr_en_i),
    .wr_addr_i(wr_addr_i),
    .wr_data_i(wr_data_i),
    .commit_i (sof_i),
    .active_o (pat_act)
  );

  frc_frame_phase u_phase (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .sof_i  (sof_i),
    .phase_o(phase)
  );

  assign x_unused = ^pix_x_i[X_W-1:POS_W];

  always_comb begin
    map     = gray_map(gray_i);
    pat_sel = pat_act[map.sel];
    slot    = 3'(pat_slot(32'(map.sel)));
    den     = slot_den(32'(slot));
    k       = phase[slot];
    // nibble k counted from the top of a 4*den-bit field
    sh      = SH_W'(NIB_W * (den - 32'(k) - 1));
    nib     = NIB_W'(pat_sel >> sh);
    pos     = pix_x_i[POS_W-1:0];
    bit_on  = nib[POS_W'(NIB_W - 1) - pos];
    pix_d   = map.fixed ? map.fixed_val : (bit_on ^ map.inv);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          pix_q <= 1'b0;
    else if (pix_valid_i) pix_q <= pix_d;
  end

  assign pix_o = pix_q;
endmodule

// File: rtl/frc_dither_chk.sv
module frc_dither_chk
  import frc_pkg::*;
(
  input logic                          clk_i,
  input logic                          rst_ni,
  input logic                          pix_valid_i,
  input logic [GRAY_W-1:0]             gray_i,
  input logic                          sof_i,
  input logic                          pix_o,
  input logic [NUM_PAT-1:0][PAT_W-1:0] act_i,
  input logic [NUM_DEN-1:0][PH_W-1:0]  phase_i
);
  assert_hold_idle_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pix_valid_i |=> $stable(pix_o));

  assert_full_on_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pix_valid_i && gray_i == 4'd15) |=> pix_o);

  assert_full_off_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pix_valid_i && gray_i == 4'd0) |=> !pix_o);

  assert_defer_write_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sof_i |=> $stable(act_i));

  assert_phase_steady_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sof_i |=> $stable(phase_i));
endmodule

bind frc_dither frc_dither_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .pix_valid_i(pix_valid_i),
  .gray_i     (gray_i),
  .sof_i      (sof_i),
  .pix_o      (pix_o),
  .act_i      (pat_act),
  .phase_i    (phase)
);

// File: tb/sim_frc_dither.sv
module sim_frc_dither;
  localparam int CLK_PERIOD = 10;
  localparam int X_W = 11;
  localparam int FRAMES = 430;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic pix_valid_i = 1'b0;
  logic [3:0] gray_i = '0;
  logic [X_W-1:0] pix_x_i = '0;
  logic sof_i = 1'b0;
  logic wr_en_i = 1'b0;
  logic [2:0] wr_addr_i = '0;
  logic [27:0] wr_data_i = '0;
  logic pix_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  logic [27:0] m_stage [8];
  logic [27:0] m_act [8];
  int fr = 0;
  bit started = 1'b0;

  frc_dither #(.X_W(X_W)) u0 (
    .clk_i(clk_i), .rst_ni(rst_ni), .pix_valid_i(pix_valid_i), .gray_i(gray_i),
    .pix_x_i(pix_x_i), .sof_i(sof_i), .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i),
    .wr_data_i(wr_data_i), .pix_o(pix_o)
  );

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  function automatic int den_of(int r);
    case (r)
      0: return 2;
      1: return 3;
      2: return 4;
      3, 4: return 5;
      default: return 7;
    endcase
  endfunction

  // R2/R3 mapping: level -> register address, inversion
  function automatic bit exp_bit(int g, int m);
    int r;
    bit inv;
    int d;
    int k;
    logic [3:0] nib;
    if (g == 0) return 1'b0;
    if (g == 15) return 1'b1;
    inv = (g <= 7);
    case (g)
      14, 1: r = 7;
      13, 2: r = 4;
      12, 3: r = 2;
      11:    r = 6;
      10, 4: r = 1;
      9, 5:  r = 3;
      8, 6:  r = 5;
      default: r = 0;
    endcase
    d = den_of(r);
    k = fr % d;                        // R6
    nib = 4'(m_act[r] >> (4 * (d - 1 - k)));  // R5
    return nib[3 - m] ^ inv;           // R4
  endfunction

  task automatic check(string tag, logic act, logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: pix_o=%0b expected %0b (frame %0d)", tag, act, exp, fr);
    end
  endtask

  task automatic put_pixel(int g, int x);
    @(negedge clk_i);
    pix_valid_i = 1'b1;
    gray_i = 4'(g);
    pix_x_i = X_W'(x);
    @(negedge clk_i);
    pix_valid_i = 1'b0;
  endtask

  task automatic write_reg(int a, logic [27:0] d);
    @(negedge clk_i);
    wr_en_i = 1'b1;
    wr_addr_i = 3'(a);
    wr_data_i = d;
    @(negedge clk_i);
    wr_en_i = 1'b0;
    m_stage[a] = (den_of(a) >= 7) ? d : (d & ((28'd1 << (4 * den_of(a))) - 28'd1));
  endtask

  task automatic frame_start();
    @(negedge clk_i);
    sof_i = 1'b1;
    @(negedge clk_i);
    sof_i = 1'b0;
    if (started) fr++;
    else started = 1'b1;
    for (int i = 0; i < 8; i++) m_act[i] = m_stage[i];
  endtask

  function automatic string tag_of(int g);
    if (g == 0 || g == 15) return "R1";
    if (g >= 8) return "R2";
    return "R3";
  endfunction

  initial begin
    repeat (CLK_PERIOD * 200000) @(posedge clk_i);
    if (!done) begin
      n_bad++;
      n_chk++;
      $display("FAIL watchdog: run did not finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 8; i++) begin
      m_stage[i] = '0;
      m_act[i] = '0;
    end
    repeat (3) @(negedge clk_i);
    check("R8 reset", pix_o, 1'b0);
    rst_ni = 1'b1;

    // R9: zero registers before any write
    put_pixel(9, 0);
    check("R9 level 9", pix_o, 1'b0);
    put_pixel(5, 2);
    check("R9 level 5", pix_o, 1'b1);

    // load patterns; address 3 holds the worked example, address 0 carries dropped upper bits (R5)
    write_reg(0, 28'hFFFFF_6C);
    write_reg(1, 28'h0000_9A3);
    write_reg(2, 28'h000_5AC3);
    write_reg(3, 28'h00_A5A5F);
    write_reg(4, 28'h00_E7B1D);
    write_reg(5, 28'h3C96A5F);
    write_reg(6, 28'hD2B7E41);
    write_reg(7, 28'hFEDB731);

    // R7: not yet committed
    put_pixel(9, 0);
    check("R7 before commit", pix_o, 1'b0);

    frame_start();   // R6: first pulse keeps phase 0

    for (int f = 0; f < FRAMES; f++) begin
      if (f < 4) begin
        put_pixel(9, 4 * f);
        check("R4 example m0", pix_o, (f % 2 == 0) ? 1'b1 : 1'b0);
        put_pixel(9, 4 * f + 1);
        check("R4 example m1", pix_o, (f % 2 == 0) ? 1'b0 : 1'b1);
      end
      for (int g = 0; g < 16; g++) begin
        if (f == 200 && g == 8) write_reg(5, 28'h1248_C03);  // R7 mid-frame write
        for (int m = 0; m < 4; m++) begin
          int x;
          x = 4 * ((f * 7 + g * 13 + m) % 400) + m;
          put_pixel(g, x);
          check(tag_of(g), pix_o, exp_bit(g, m));
        end
      end
      frame_start();
    end

    // R8: hold while strobe low
    put_pixel(15, 3);
    check("R8 after level 15", pix_o, 1'b1);
    @(negedge clk_i);
    gray_i = 4'd0;
    repeat (3) @(negedge clk_i);
    check("R8 hold idle", pix_o, 1'b1);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule